// File: doc/BRIEF.md
# Comma-Aligning 10-bit Deserializer

This block turns a retimed serial bit stream into 10-bit receive code groups. A bit is taken on every clock where the bit strobe is high. The first bit of each group lands in bit 0. When ten bits have been collected, the block emits the group with a one-cycle valid strobe.

While alignment is enabled, the block watches the stream for the seven-bit comma+ marker. When the marker appears, the block moves the group boundary so that the marker fills bits 0 to 6 of the next word it emits. Any bits already collected for the group in progress are thrown away. The new boundary is kept until another marker moves it. When alignment is disabled, the boundary stays where it is.

A signal-detect level gates the output. A word completed while the level is low comes out as all ones. Clock recovery, equalization and 8B/10B decoding are outside this block.

Top module: `comma_deser`

## Requirements
- R1: While rstN is low, cgValid and markFound are low and cgOut is all zeros.
- R2: The first bit taken for a group appears at cgOut bit 0, and each later bit appears at the next higher position. cgValid pulses for exactly one cycle, in the cycle after the edge that takes the tenth bit, and cgOut then holds the word until the next emission.
- R3: A bit is taken only on an edge where bitValid is high. Edges with bitValid low change neither the group in progress nor the outputs.
- R4: The marker is the last seven bits taken, read from oldest to newest: 0,0,1,1,1,1,1. When alignEn is high on the edge that takes the newest bit of a marker, those seven bits become bits 0 to 6 of the current group. The group is then emitted after three more bits, and the earlier partial group is dropped without being emitted.
- R5: After a realignment, later groups are emitted every ten bits on the new boundary, until another marker appears.
- R6: When alignEn is low, a marker in the stream has no effect on the boundary.
- R7: A word completed on an edge where sigDet is low is emitted as all ones (cgOut = 10'h3FF).
- R8: markFound pulses together with cgValid when alignEn was high on the completing edge and the emitted word has bits 6:0 equal to 7'b1111100 (bit 0 = 0, bit 1 = 0, bits 2 to 6 = 1). Otherwise markFound stays low.
- R9: After reset, the first word is emitted after the first ten bits, with no marker needed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Retimed serial data bit |
| bitValid | input | 1 | Takes bitIn on this edge |
| alignEn | input | 1 | Allows realignment on the marker |
| sigDet | input | 1 | Signal present; when low, emitted words are forced to all ones |
| cgOut | output | 10 | Last emitted code group |
| cgValid | output | 1 | One-cycle strobe for a new code group |
| markFound | output | 1 | Emitted word is an aligned marker word |

## Verification
The block is driven with each of the following input patterns, and each one separates a different fault:

- **Continuous random bits with alignment off.** This fixes the basic group timing and the bit order. A reversed order or a counter that is off by one shows up in the first word.
- **Gapped bit strobes.** These show whether bits are taken only when the strobe is high.
- **A marker placed at a known offset with alignment on.** This shows whether the boundary moves, whether the partial group is dropped, and whether markFound fires.
- **A marker at a new offset with alignment off.** This confirms that the old boundary is held.
- **Random toggling of sigDet and alignEn.** This exercises the all-ones gate and the marker strobe together.

// File: rtl/cdes_pkg.sv
package cdes_pkg;
  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic shift;    // take bitIn into the window
    logic emit;     // group complete, register the word
    logic realign;  // marker seen, restart the group
  } ctrlStrobes_t;
endpackage

// File: rtl/cdes_ctrl.sv
module cdes_ctrl
  import cdes_pkg::*;
#(
  parameter int GROUP_W = 10,
  parameter int MARK_W  = 7,
  parameter logic [MARK_W-1:0] MARK = 7'b1111100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic              alignEn,
  input  logic [MARK_W-2:0] winUpper,
  output ctrlStrobes_t      strobes
);
  localparam int CW = $clog2(GROUP_W);
  localparam logic [CW-1:0] LAST_POS = CW'(GROUP_W - 1);
  localparam logic [CW-1:0] MARK_POS = CW'(MARK_W);

  logic [CW-1:0] bitCnt;
  logic          markHit;

  // The newest bit plus the upper window bits form the last MARK_W bits taken.
  assign markHit = alignEn && ({bitIn, winUpper} == MARK);

  always_comb begin
    strobes.shift   = bitValid;
    strobes.realign = bitValid && markHit;
    strobes.emit    = bitValid && !markHit && (bitCnt == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                bitCnt <= '0;
    else if (strobes.realign) bitCnt <= MARK_POS;
    else if (strobes.emit)    bitCnt <= '0;
    else if (strobes.shift)   bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/cdes_datapath.sv
module cdes_datapath
  import cdes_pkg::*;
#(
  parameter int GROUP_W = 10,
  parameter int MARK_W  = 7,
  parameter logic [MARK_W-1:0] MARK = 7'b1111100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               alignEn,
  input  logic               sigDet,
  input  ctrlStrobes_t       strobes,
  output logic [MARK_W-2:0]  winUpper,
  output logic [GROUP_W-1:0] cgOut,
  output logic               cgValid,
  output logic               markFound
);
  logic [GROUP_W-1:0] window;
  logic [GROUP_W-1:0] nextWin;
  logic [GROUP_W-1:0] gatedWord;

  // Serial order is LSB first: new bits enter at the top and move downward.
  assign nextWin   = {bitIn, window[GROUP_W-1:1]};
  assign gatedWord = sigDet ? nextWin : '1;
  assign winUpper  = window[GROUP_W-1 -: (MARK_W-1)];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window    <= '0;
      cgOut     <= '0;
      cgValid   <= 1'b0;
      markFound <= 1'b0;
    end else begin
      if (strobes.shift) window <= nextWin;
      if (strobes.emit)  cgOut  <= gatedWord;
      cgValid   <= strobes.emit;
      markFound <= strobes.emit && alignEn && (gatedWord[MARK_W-1:0] == MARK);
    end
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import cdes_pkg::*;
#(
  parameter int GROUP_W = 10,
  parameter int MARK_W  = 7,
  parameter logic [MARK_W-1:0] MARK = 7'b1111100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitIn,
  input  logic               bitValid,
  input  logic               alignEn,
  input  logic               sigDet,
  output logic [GROUP_W-1:0] cgOut,
  output logic               cgValid,
  output logic               markFound
);
  ctrlStrobes_t      strobes;
  logic [MARK_W-2:0] winUpper;

  cdes_ctrl #(.GROUP_W(GROUP_W), .MARK_W(MARK_W), .MARK(MARK)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .alignEn(alignEn), .winUpper(winUpper), .strobes(strobes)
  );

  cdes_datapath #(.GROUP_W(GROUP_W), .MARK_W(MARK_W), .MARK(MARK)) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .alignEn(alignEn), .sigDet(sigDet),
    .strobes(strobes), .winUpper(winUpper), .cgOut(cgOut),
    .cgValid(cgValid), .markFound(markFound)
  );
endmodule

// File: rtl/cdes_checker.sv
module cdes_checker #(
  parameter int GROUP_W = 10,
  parameter int MARK_W  = 7,
  parameter logic [MARK_W-1:0] MARK = 7'b1111100
) (
  input logic               clk,
  input logic               rstN,
  input logic               bitValid,
  input logic               alignEn,
  input logic               sigDet,
  input logic [GROUP_W-1:0] cgOut,
  input logic               cgValid,
  input logic               markFound
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!cgValid && !markFound));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cgValid |=> !cgValid);

  // R3
  word_needs_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cgValid |-> $past(bitValid));

  // R7
  loss_forces_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cgValid && !$past(sigDet)) |-> (cgOut == '1));

  // R8
  mark_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    markFound |-> (cgValid && (cgOut[MARK_W-1:0] == MARK)));

  // R8
  mark_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    markFound |-> $past(alignEn));
endmodule

bind comma_deser cdes_checker #(.GROUP_W(GROUP_W), .MARK_W(MARK_W), .MARK(MARK)) u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .alignEn(alignEn), .sigDet(sigDet),
  .cgOut(cgOut), .cgValid(cgValid), .markFound(markFound)
);

// File: tb/test_comma_deser.sv
module test_comma_deser;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0, bitValid = 1'b0, alignEn = 1'b0, sigDet = 1'b1;
  logic [9:0] cgOut;
  logic       cgValid, markFound;

  int checks = 0, errors = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model state
  bit   hist[$];
  bit   grp[$];
  logic [9:0] expWord = '0;
  logic expValid = 1'b0, expMark = 1'b0;
  int   markSeen = 0, stepNo = 0, firstValidStep = -1;

  always #2.5 clk = ~clk;

  comma_deser i_comma_deser (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .alignEn(alignEn), .sigDet(sigDet), .cgOut(cgOut),
    .cgValid(cgValid), .markFound(markFound)
  );

  function automatic bit markBit(int k);
    return (k >= 2);
  endfunction

  task automatic check(string tag, bit ok, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // One cycle: compare the outputs from the last edge, then drive and model the next one.
  task automatic step(logic v, logic b, logic d, logic s);
    @(negedge clk);
    stepNo++;
    check(curTag, (cgValid === expValid) && (markFound === expMark) && (cgOut === expWord),
          $sformatf("got valid=%0b word=%h mark=%0b expected valid=%0b word=%h mark=%0b",
                    cgValid, cgOut, markFound, expValid, expWord, expMark));
    if (cgValid === 1'b1) begin
      if (markFound === 1'b1) markSeen++;
      if (firstValidStep < 0) firstValidStep = stepNo;
    end
    bitValid = v; bitIn = b; alignEn = d; sigDet = s;
    expValid = 1'b0; expMark = 1'b0;
    if (v) begin
      bit hit;
      hist.push_back(b);
      if (hist.size() > 7) void'(hist.pop_front());
      grp.push_back(b);
      hit = d;
      for (int k = 0; k < 7; k++) if (hist[k] != markBit(k)) hit = 0;
      if (hit) begin
        grp = hist;
      end else if (grp.size() == 10) begin
        logic [9:0] w;
        for (int k = 0; k < 10; k++) w[k] = grp[k];
        grp.delete();
        expWord  = s ? w : 10'h3FF;
        expValid = 1'b1;
        expMark  = d && (expWord[6:0] == 7'b1111100);
      end
    end
  endtask

  task automatic sendBits(logic [31:0] pat, int n, logic d);
    for (int i = 0; i < n; i++) step(1'b1, pat[i], d, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) hist.push_back(1'b0); // reset window holds zeros
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check("R1", (cgValid === 1'b0) && (markFound === 1'b0) && (cgOut === 10'h000),
          $sformatf("got valid=%0b word=%h mark=%0b expected 0 000 0", cgValid, cgOut, markFound));
    rstN = 1'b1;
    stepNo = 0;

    // R2 / R9: continuous bits, alignment off
    curTag = "R2";
    for (int i = 0; i < 40; i++) step(1'b1, 1'($urandom % 2), 1'b0, 1'b1);
    check("R9", firstValidStep == 11,
          $sformatf("first word at step %0d expected 11", firstValidStep));

    // R3: gapped strobes
    curTag = "R3";
    for (int i = 0; i < 80; i++) step(1'($urandom % 2), 1'($urandom % 2), 1'b0, 1'b1);

    // R4: marker at known offset with alignment on
    curTag = "R4";
    markSeen = 0;
    sendBits(32'b101, 3, 1'b1);
    sendBits(32'b010_1111100, 10, 1'b1);
    sendBits(32'b1010_010101, 10, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    check("R8", markSeen > 0, $sformatf("mark strobes %0d expected >0", markSeen));

    // R5: boundary held on later groups
    curTag = "R5";
    for (int i = 0; i < 200; i++) step(1'b1, 1'($urandom % 2), 1'b1, 1'b1);

    // R6: marker at new offset with alignment off
    curTag = "R6";
    markSeen = 0;
    sendBits(32'b01, 2, 1'b0);
    sendBits(32'b110_1111100, 10, 1'b0);
    sendBits(32'b0101010101, 10, 1'b0);
    sendBits(32'b0110011001, 10, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6", markSeen == 0, $sformatf("mark strobes %0d expected 0", markSeen));

    // R7 / R8: signal loss and enable toggling
    curTag = "R7";
    for (int i = 0; i < 300; i++)
      step(1'($urandom % 4 != 0), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 3 != 0));
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule